// File: doc/BRIEF.md
# Procedure Migration Request Coordinator

This block sits at cluster level and moves a procedure call from a core that should not run it to a core that can. Every core has a call port. A call carries a procedure index, the core's vulnerability score for that procedure at its present operating point, and a limit. If the score does not exceed the limit, the core is told to run the procedure locally and nothing else happens. If the score exceeds the limit, the block records the call in a per-procedure status table and offers it to the whole cluster on a broadcast bus.

Other cores answer the offer with their own score. A core may take the work only when its score is at or below the stored limit. The caller itself cannot take it, and neither can a core that is already serving another procedure. When several cores qualify, the lowest-numbered one wins and the others are told they lost. The winner later reports completion. The block then pulses an acknowledge for that procedure and raises a done level toward the caller. The caller consumes the result, which frees the entry.

Each caller has a timer. If no completion has arrived after the timeout, the caller gets a fail pulse, the entry is cleared and the procedure can run locally. Any completion that arrives after that is dropped. Each table entry holds a 2-bit state (idle 00, requested 01, running 10, done 11), the caller index, the callee index and the limit.

Top module: `hop_coord`

## Requirements
- R1: After reset every output pulse, every done level and the broadcast valid are low.
- R2: A call whose score is less than or equal to its limit gives a one-cycle go_local pulse for that core in the cycle after it is sampled. It creates no entry, raises no error and starts no broadcast.
- R3: A call whose score exceeds its limit, from a core with nothing pending and for an idle procedure, is broadcast from the next cycle on. bcast_proc carries the procedure and bcast_caller carries the caller. When several entries are waiting, the lowest procedure index is broadcast.
- R4: An answer counts only if it comes from a core that is not the caller, whose score is at or below the stored limit, and that is not currently serving an entry. Answers that do not count give neither a win nor a lost pulse.
- R5: Among the answers that count in one cycle, the lowest core index receives a hop_win pulse and the other counting cores receive hop_lost, one cycle later. The entry then stops being broadcast.
- R6: A completion from the serving core pulses the procedure's bit in ack_mask in the next cycle. From that cycle on, it also holds the caller's hop_done high.
- R7: A take from a caller whose hop_done is high drops hop_done in the next cycle and frees the procedure for a new call.
- R8: A migrating call from a core that already has a pending entry, or for a procedure whose entry is not idle, gives a hop_err pulse and changes nothing. If two cores call for the same idle procedure in one cycle, the lower index gets the entry and the other gets hop_err.
- R9: If the entry is not done TIMEOUT cycles after the call was sampled, the caller gets a hop_fail pulse and the entry is freed. A completion sampled on that same edge takes priority: the result is ack and done, with no fail.
- R10: A completion from a core whose entry has already timed out gives no ack and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | N | Call strobe per core |
| req_proc | input | N*PW | Procedure index per core |
| req_score | input | N*SW | Caller score per core |
| req_thresh | input | N*SW | Limit per core |
| take | input | N | Caller consumes a finished result |
| rsp_valid | input | N | Answer to the current broadcast per core |
| rsp_score | input | N*SW | Answering core's score |
| fin_valid | input | N | Serving core reports completion |
| go_local | output | N | Run the procedure locally |
| hop_err | output | N | Call rejected |
| hop_done | output | N | Result ready for the caller |
| hop_fail | output | N | Caller timed out |
| hop_win | output | N | Core was chosen as callee |
| hop_lost | output | N | Core qualified but was not chosen |
| bcast_valid | output | 1 | A request is on offer |
| bcast_proc | output | PW | Procedure on offer |
| bcast_caller | output | CW | Caller of the offered procedure |
| ack_mask | output | NPROC | Completion acknowledge per procedure |

## Verification
Every pulse (go_local, hop_err, hop_win, hop_lost, hop_fail, ack_mask) comes from a register. It is due in the cycle after the edge that sampled its cause. bcast_valid and hop_done are decoded from registered state, so they change in that same cycle. The bench drives inputs 1 ns after a rising edge, advances one edge and then compares. It counts edges from the sampled call, so hop_fail is checked exactly on edge TIMEOUT, with a no-fail check one edge earlier. A full sweep over score and limit pairs takes each call down the local path, the accepted round trip or the timeout path, and computes the expected winner arithmetically from the chosen answer scores.

// File: rtl/hop_pkg.sv
package hop_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_REQ  = 2'b01,
        ST_RUN  = 2'b10,
        ST_DONE = 2'b11
    } hop_st_e;
endpackage

// File: rtl/hop_pick_low.sv
module hop_pick_low #(
    parameter int W  = 16,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hop_qualify.sv
module hop_qualify #(
    parameter int N  = 16,
    parameter int SW = 8,
    parameter int CW = 4
) (
    input  logic          offer,
    input  logic [CW-1:0] caller,
    input  logic [SW-1:0] limit,
    input  logic [N-1:0]  rsp_valid,
    input  logic [N*SW-1:0] rsp_score,
    input  logic [N-1:0]  serving,
    output logic [N-1:0]  qual
);
    for (genvar k = 0; k < N; k++) begin : g_core
        assign qual[k] = offer && rsp_valid[k] && !serving[k]
                         && (rsp_score[k*SW +: SW] <= limit)
                         && (caller != CW'(k));
    end
endmodule

// File: rtl/hop_coord.sv
module hop_coord
    import hop_pkg::*;
#(
    parameter int N       = 16,
    parameter int NPROC   = 8,
    parameter int SW      = 8,
    parameter int TIMEOUT = 800,
    localparam int CW = (N > 1) ? $clog2(N) : 1,
    localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int TW = $clog2(TIMEOUT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      req_valid,
    input  logic [N*PW-1:0]   req_proc,
    input  logic [N*SW-1:0]   req_score,
    input  logic [N*SW-1:0]   req_thresh,
    input  logic [N-1:0]      take,
    input  logic [N-1:0]      rsp_valid,
    input  logic [N*SW-1:0]   rsp_score,
    input  logic [N-1:0]      fin_valid,
    output logic [N-1:0]      go_local,
    output logic [N-1:0]      hop_err,
    output logic [N-1:0]      hop_done,
    output logic [N-1:0]      hop_fail,
    output logic [N-1:0]      hop_win,
    output logic [N-1:0]      hop_lost,
    output logic              bcast_valid,
    output logic [PW-1:0]     bcast_proc,
    output logic [CW-1:0]     bcast_caller,
    output logic [NPROC-1:0]  ack_mask
);
    typedef struct packed {
        hop_st_e       st;
        logic [CW-1:0] caller;
        logic [CW-1:0] callee;
        logic [SW-1:0] limit;
    } entry_t;

    typedef struct packed {
        logic          pend;
        logic [PW-1:0] proc;
        logic [TW-1:0] tmr;
    } slot_t;

    typedef struct packed {
        entry_t [NPROC-1:0] ent;
        slot_t  [N-1:0]     slot;
        logic   [N-1:0]     loc;
        logic   [N-1:0]     err;
        logic   [N-1:0]     fail;
        logic   [N-1:0]     win;
        logic   [N-1:0]     lost;
        logic   [NPROC-1:0] ack;
    } state_t;

    state_t s_d, s_q;

    logic [NPROC-1:0] waiting;
    logic [N-1:0]     serving;
    logic [N-1:0]     qual;
    logic [N-1:0]     win_oh;
    logic [PW-1:0]    bsel;
    logic             bany;
    logic [CW-1:0]    win_idx;
    logic             win_any;

    always_comb begin
        serving = '0;
        for (int p = 0; p < NPROC; p++) begin
            waiting[p] = (s_q.ent[p].st == ST_REQ);
            if (s_q.ent[p].st == ST_RUN) begin
                serving[s_q.ent[p].callee] = 1'b1;
            end
        end
    end

    hop_pick_low #(.W(NPROC)) i_offer_pick (
        .vec(waiting), .idx(bsel), .any(bany)
    );

    hop_qualify #(.N(N), .SW(SW), .CW(CW)) i_qualify (
        .offer(bany), .caller(s_q.ent[bsel].caller), .limit(s_q.ent[bsel].limit),
        .rsp_valid(rsp_valid), .rsp_score(rsp_score), .serving(serving), .qual(qual)
    );

    hop_pick_low #(.W(N)) i_win_pick (
        .vec(qual), .idx(win_idx), .any(win_any)
    );

    assign win_oh = win_any ? (N'(1) << win_idx) : '0;

    always_comb begin
        logic [PW-1:0] rp;
        logic [SW-1:0] rs;
        logic [SW-1:0] rt;
        s_d      = s_q;
        s_d.loc  = '0;
        s_d.err  = '0;
        s_d.fail = '0;
        s_d.win  = '0;
        s_d.lost = '0;
        s_d.ack  = '0;

        // callee selection on the offered entry
        if (win_any) begin
            s_d.ent[bsel].st     = ST_RUN;
            s_d.ent[bsel].callee = win_idx;
            s_d.win              = win_oh;
            s_d.lost             = qual & ~win_oh;
        end

        // completions from serving cores
        for (int k = 0; k < N; k++) begin
            if (fin_valid[k]) begin
                for (int p = 0; p < NPROC; p++) begin
                    if (s_q.ent[p].st == ST_RUN && s_q.ent[p].callee == CW'(k)) begin
                        s_d.ent[p].st = ST_DONE;
                        s_d.ack[p]    = 1'b1;
                    end
                end
            end
        end

        // caller consumes a finished result
        for (int i = 0; i < N; i++) begin
            if (take[i] && s_q.slot[i].pend && s_q.ent[s_q.slot[i].proc].st == ST_DONE) begin
                s_d.ent[s_q.slot[i].proc].st = ST_IDLE;
                s_d.slot[i].pend             = 1'b0;
            end
        end

        // caller timers; a completion on the same edge prevails
        for (int i = 0; i < N; i++) begin
            if (s_d.slot[i].pend && s_d.ent[s_d.slot[i].proc].st != ST_DONE) begin
                if (s_q.slot[i].tmr == TW'(TIMEOUT - 1)) begin
                    s_d.fail[i]                  = 1'b1;
                    s_d.ent[s_d.slot[i].proc].st = ST_IDLE;
                    s_d.slot[i].pend             = 1'b0;
                end else begin
                    s_d.slot[i].tmr = s_q.slot[i].tmr + 1'b1;
                end
            end
        end

        // new calls, lower core index first
        for (int i = 0; i < N; i++) begin
            rp = req_proc[i*PW +: PW];
            rs = req_score[i*SW +: SW];
            rt = req_thresh[i*SW +: SW];
            if (req_valid[i]) begin
                if (rs <= rt) begin
                    s_d.loc[i] = 1'b1;
                end else if (s_d.slot[i].pend || s_d.ent[rp].st != ST_IDLE) begin
                    s_d.err[i] = 1'b1;
                end else begin
                    s_d.ent[rp].st     = ST_REQ;
                    s_d.ent[rp].caller = CW'(i);
                    s_d.ent[rp].callee = '0;
                    s_d.ent[rp].limit  = rt;
                    s_d.slot[i].pend   = 1'b1;
                    s_d.slot[i].proc   = rp;
                    s_d.slot[i].tmr    = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            hop_done[i] = s_q.slot[i].pend && (s_q.ent[s_q.slot[i].proc].st == ST_DONE);
        end
    end

    assign go_local     = s_q.loc;
    assign hop_err      = s_q.err;
    assign hop_fail     = s_q.fail;
    assign hop_win      = s_q.win;
    assign hop_lost     = s_q.lost;
    assign ack_mask     = s_q.ack;
    assign bcast_valid  = bany;
    assign bcast_proc   = bsel;
    assign bcast_caller = s_q.ent[bsel].caller;
endmodule

// File: rtl/hop_coord_chk.sv
module hop_coord_chk #(
    parameter int N     = 16,
    parameter int NPROC = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     req_valid,
    input logic [N-1:0]     fin_valid,
    input logic [N-1:0]     go_local,
    input logic [N-1:0]     hop_err,
    input logic [N-1:0]     hop_done,
    input logic [N-1:0]     hop_fail,
    input logic [N-1:0]     hop_win,
    input logic [N-1:0]     hop_lost,
    input logic             bcast_valid,
    input logic [NPROC-1:0] ack_mask
);
    AST_LOCAL_HAS_CALL: assert property (@(posedge clk) disable iff (!rst_n)
        (|go_local) |-> $past(|req_valid)); // R2
    AST_LOCAL_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (go_local & hop_err) == '0); // R8
    AST_WIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hop_win)); // R5
    AST_WIN_LOST_APART: assert property (@(posedge clk) disable iff (!rst_n)
        (hop_win & hop_lost) == '0); // R5
    AST_WIN_NEEDS_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        (|hop_win) |-> $past(bcast_valid)); // R4
    AST_ACK_NEEDS_FIN: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_mask) |-> $past(|fin_valid)); // R6
    AST_FAIL_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (hop_fail & hop_done) == '0); // R9
endmodule

bind hop_coord hop_coord_chk #(.N(N), .NPROC(NPROC)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .fin_valid(fin_valid),
    .go_local(go_local), .hop_err(hop_err), .hop_done(hop_done), .hop_fail(hop_fail),
    .hop_win(hop_win), .hop_lost(hop_lost), .bcast_valid(bcast_valid), .ack_mask(ack_mask)
);

// File: tb/test_hop_coord.sv
module test_hop_coord;
    localparam int N = 4, NP = 4, SW = 4, TO = 20, PW = 2, CW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0] req_valid, take, rsp_valid, fin_valid;
    logic [N*PW-1:0] req_proc;
    logic [N*SW-1:0] req_score, req_thresh, rsp_score;
    logic [N-1:0] go_local, hop_err, hop_done, hop_fail, hop_win, hop_lost;
    logic bcast_valid;
    logic [PW-1:0] bcast_proc;
    logic [CW-1:0] bcast_caller;
    logic [NP-1:0] ack_mask;
    int nchk = 0, nfail = 0, cyc = 0;

    always #4 clk = ~clk;

    hop_coord #(.N(N), .NPROC(NP), .SW(SW), .TIMEOUT(TO)) i_hop_coord (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_proc(req_proc),
        .req_score(req_score), .req_thresh(req_thresh), .take(take),
        .rsp_valid(rsp_valid), .rsp_score(rsp_score), .fin_valid(fin_valid),
        .go_local(go_local), .hop_err(hop_err), .hop_done(hop_done), .hop_fail(hop_fail),
        .hop_win(hop_win), .hop_lost(hop_lost), .bcast_valid(bcast_valid),
        .bcast_proc(bcast_proc), .bcast_caller(bcast_caller), .ack_mask(ack_mask)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        cyc++;
    endtask

    task automatic idle_inputs();
        req_valid = '0; req_proc = '0; req_score = '0; req_thresh = '0;
        take = '0; rsp_valid = '0; rsp_score = '0; fin_valid = '0;
    endtask

    task automatic call(input int i, input int p, input int s, input int t);
        req_valid[i] = 1'b1;
        req_proc[i*PW +: PW] = PW'(p);
        req_score[i*SW +: SW] = SW'(s);
        req_thresh[i*SW +: SW] = SW'(t);
    endtask

    task automatic answer(input int k, input int s);
        rsp_valid[k] = 1'b1;
        rsp_score[k*SW +: SW] = SW'(s);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: got hung expected completion");
        finish_run();
    end

    initial begin
        int rq;
        idle_inputs();
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1", "go_local", int'(go_local), 0);
        check("R1", "hop_done", int'(hop_done), 0);
        check("R1", "hop_fail|win|lost", int'(hop_fail | hop_win | hop_lost), 0);
        check("R1", "bcast_valid", int'(bcast_valid), 0);
        check("R1", "ack_mask", int'(ack_mask), 0);

        // sweep of score/limit pairs through local, accepted and timeout paths
        for (int s = 0; s < 16; s++) begin
            for (int t = 0; t < 16; t++) begin
                int i, p, w, rs;
                logic [N-1:0] qv, woh;
                i = (s + t) % N;
                p = s % NP;
                idle_inputs();
                call(i, p, s, t);
                step();
                idle_inputs();
                check("R8", "hop_err on fresh call", int'(hop_err), 0);
                if (s <= t) begin
                    check("R2", "go_local", int'(go_local), 1 << i);
                    check("R2", "no broadcast", int'(bcast_valid), 0);
                end else begin
                    check("R2", "no go_local", int'(go_local), 0);
                    check("R3", "bcast_valid", int'(bcast_valid), 1);
                    check("R3", "bcast_proc", int'(bcast_proc), p);
                    check("R3", "bcast_caller", int'(bcast_caller), i);
                    qv = '0;
                    for (int k = 0; k < N; k++) begin
                        rs = (k * 5 + s + t) % 16;
                        answer(k, rs);
                        if (k != i && rs <= t) qv[k] = 1'b1;
                    end
                    w = -1;
                    for (int k = N - 1; k >= 0; k--) if (qv[k]) w = k;
                    step();
                    idle_inputs();
                    if (w >= 0) begin
                        woh = N'(1) << w;
                        check("R5", "hop_win", int'(hop_win), int'(woh));
                        check("R5", "hop_lost", int'(hop_lost), int'(qv & ~woh));
                        check("R5", "offer withdrawn", int'(bcast_valid), 0);
                        fin_valid[w] = 1'b1;
                        step();
                        idle_inputs();
                        check("R6", "ack_mask", int'(ack_mask), 1 << p);
                        check("R6", "hop_done", int'(hop_done), 1 << i);
                        take[i] = 1'b1;
                        step();
                        idle_inputs();
                        check("R7", "hop_done after take", int'(hop_done), 0);
                    end else begin
                        check("R4", "no hop_win", int'(hop_win), 0);
                        check("R4", "no hop_lost", int'(hop_lost), 0);
                        repeat (TO - 2) step();
                        check("R9", "no early fail", int'(hop_fail), 0);
                        step();
                        check("R9", "hop_fail", int'(hop_fail), 1 << i);
                        check("R9", "offer cleared", int'(bcast_valid), 0);
                    end
                end
            end
        end

        // rejection, priority and serving exclusion
        idle_inputs();
        call(0, 1, 5, 2);
        step();
        idle_inputs();
        check("R3", "bcast_proc", int'(bcast_proc), 1);
        call(0, 2, 9, 3);
        call(1, 1, 9, 3);
        step();
        idle_inputs();
        check("R8", "pending caller and busy entry", int'(hop_err), 4'b0011);
        call(2, 2, 9, 3);
        call(3, 2, 9, 3);
        step();
        rq = cyc;
        idle_inputs();
        check("R8", "same-cycle contest", int'(hop_err), 4'b1000);
        check("R3", "lowest entry offered", int'(bcast_proc), 1);
        check("R3", "its caller", int'(bcast_caller), 0);
        answer(0, 0);
        answer(1, 1);
        answer(2, 2);
        answer(3, 3);
        step();
        idle_inputs();
        check("R5", "hop_win", int'(hop_win), 4'b0010);
        check("R4", "hop_lost excludes caller and over-limit", int'(hop_lost), 4'b0100);
        check("R3", "next entry offered", int'(bcast_proc), 2);
        check("R3", "next caller", int'(bcast_caller), 2);
        answer(1, 0);
        answer(2, 0);
        answer(3, 1);
        step();
        idle_inputs();
        check("R4", "serving core skipped", int'(hop_win), 4'b1000);
        check("R4", "no lost", int'(hop_lost), 0);
        fin_valid[1] = 1'b1;
        step();
        idle_inputs();
        check("R6", "ack_mask", int'(ack_mask), 4'b0010);
        check("R6", "hop_done", int'(hop_done), 4'b0001);
        take[0] = 1'b1;
        step();
        idle_inputs();
        check("R7", "hop_done cleared", int'(hop_done), 0);
        while (cyc < rq + TO - 1) step();
        check("R9", "no early fail", int'(hop_fail), 0);
        step();
        check("R9", "running entry times out", int'(hop_fail), 4'b0100);
        fin_valid[3] = 1'b1;
        step();
        idle_inputs();
        check("R10", "late completion ack", int'(ack_mask), 0);
        check("R10", "late completion done", int'(hop_done), 0);
        call(3, 2, 9, 3);
        step();
        rq = cyc;
        idle_inputs();
        check("R7", "freed entry accepts call", int'(hop_err), 0);
        check("R7", "freed entry offered", int'(bcast_caller), 3);
        while (cyc < rq + TO) step();
        check("R9", "idle-offer timeout", int'(hop_fail), 4'b1000);

        // completion on the timeout edge prevails
        call(0, 0, 8, 4);
        step();
        rq = cyc;
        idle_inputs();
        answer(1, 0);
        step();
        idle_inputs();
        check("R5", "hop_win", int'(hop_win), 4'b0010);
        while (cyc < rq + TO - 1) step();
        fin_valid[1] = 1'b1;
        step();
        idle_inputs();
        check("R9", "tie: no fail", int'(hop_fail), 0);
        check("R9", "tie: ack", int'(ack_mask), 4'b0001);
        check("R9", "tie: done", int'(hop_done), 4'b0001);
        take[0] = 1'b1;
        step();
        idle_inputs();
        check("R7", "hop_done cleared", int'(hop_done), 0);
        step();
        check("R9", "no fail after take", int'(hop_fail), 0);
        finish_run();
    end
endmodule